// File: doc/BRIEF.md
# Trial Trim Code Counter

This block holds the trial value of a programmable switching sensor's parameters during a temporary "try" session. A pulse decoder upstream reports two kinds of event: the end of a register selection key (with the register it names) and the falling edge of each mid-level programming pulse. The block keeps one shared code counter and presents it through one of five trial registers. Four of them are views onto the operate-point setting. The fifth drives the output-control field and the fuse margin check selects.

The four operate-point views differ in two ways. The first is whether the magnitude is the count itself or its inverse, so a sweep can climb up or come down. The second is whether they apply south or north field polarity. The output register packs fall time and output polarity into one summed code. Every effective parameter is the bitwise OR of the permanently blown fuse bits and the trial bits.

A synchronous power-on reset models a supply cycle. It clears all trial state, and the fuse inputs pass through unchanged.

Top module: `trim_try_core`

## Requirements
- R1: While `rst` is high at a clock edge, the block deselects every register and clears the counter. After that edge no trial bit is set, so every parameter output equals its fuse input and both check selects are 0.
- R2: `key_go` high at a clock edge selects the register coded on `key_reg` and loads the counter with 1. The codes are: 1 south up-counting, 2 north up-counting, 3 south down-counting, 4 north down-counting, 5 output/check register. Codes 0, 6 and 7 mean no register, and they load the counter with 0.
- R3: When `mid_fall` is high at a clock edge, `key_go` is low and a register is selected, the counter increases by one.
- R4: The counter is 8 bits wide. After 255, the next counted pulse gives 0.
- R5: In the up-counting views the trial magnitude equals the count. In the down-counting views it equals 255 minus the count, so code 1 gives 254 and code 0 gives 255.
- R6: Views 1 and 3 set trial polarity 0 (south). Views 2 and 4 set trial polarity 1 (north). No other register sets polarity or magnitude trial bits.
- R7: With the output register selected and a code below 8, code bits 1:0 drive the fall-time trial bits and code bit 2 drives the output-inversion trial bit. Code 7, for example, gives fall 3 and inversion 1. Codes 8 and above set no output trial bits.
- R8: With the output register selected, code 8 raises `chk_intact` only, and code 9 raises `chk_blown` only. The two are never high together, and both are 0 in any other state.
- R9: Each effective output is the bitwise OR of its fuse input and its trial bits. A blown fuse bit therefore reads 1 whatever the trial code is.
- R10: A `mid_fall` while no register is selected leaves the counter and all outputs unchanged.
- R11: If `key_go` and `mid_fall` are both high at the same edge, the key load wins and the counter holds 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset (supply cycle) |
| key_go | input | 1 | One-cycle event: selection key completed |
| key_reg | input | 3 | Register named by the completed key |
| mid_fall | input | 1 | One-cycle event: falling edge of a mid-level pulse |
| fuse_mag | input | 8 | Blown fuse bits of the operate-point magnitude |
| fuse_pol | input | 1 | Blown fuse bit of the operate-point polarity |
| fuse_fall | input | 2 | Blown fuse bits of the fall-time field |
| fuse_inv | input | 1 | Blown fuse bit of output inversion |
| op_mag | output | 8 | Effective operate-point magnitude |
| op_pol | output | 1 | Effective operate-point polarity (0 south, 1 north) |
| out_fall | output | 2 | Effective fall-time selection |
| out_inv | output | 1 | Effective output inversion |
| chk_intact | output | 1 | Margin check of intact fuses selected |
| chk_blown | output | 1 | Margin check of blown fuses selected |

## Verification
A key completion and a mid-level pulse can land on the same clock edge, and so can a reset and either event. The random phase raises `key_go` and `mid_fall` independently on each cycle, so both collisions occur many times. A directed step also forces the key-versus-pulse collision on purpose. Each outcome is judged against a bench model that gives the key priority over the pulse and the reset priority over both. The check looks at the next cycle's magnitude, polarity and output field, which reveal whether the count went to 1 or to the old count plus one.

// File: rtl/trim_pkg.sv
package trim_pkg;

    typedef enum logic [2:0] {
        VREG_NONE   = 3'd0,
        VREG_POS_UP = 3'd1,
        VREG_NEG_UP = 3'd2,
        VREG_POS_DN = 3'd3,
        VREG_NEG_DN = 3'd4,
        VREG_OUT    = 3'd5
    } vreg_e;

    typedef struct packed {
        logic [1:0] fall;
        logic       inv;
    } outctl_t;

    typedef struct packed {
        logic intact;
        logic blown;
    } fchk_t;

    function automatic vreg_e decode_key(input logic [2:0] raw);
        case (raw)
            3'd1:    return VREG_POS_UP;
            3'd2:    return VREG_NEG_UP;
            3'd3:    return VREG_POS_DN;
            3'd4:    return VREG_NEG_DN;
            3'd5:    return VREG_OUT;
            default: return VREG_NONE;
        endcase
    endfunction

    function automatic logic is_point_view(input vreg_e v);
        return (v == VREG_POS_UP) || (v == VREG_NEG_UP) ||
               (v == VREG_POS_DN) || (v == VREG_NEG_DN);
    endfunction

    function automatic logic is_down_view(input vreg_e v);
        return (v == VREG_POS_DN) || (v == VREG_NEG_DN);
    endfunction

    function automatic logic is_north_view(input vreg_e v);
        return (v == VREG_NEG_UP) || (v == VREG_NEG_DN);
    endfunction

endpackage

// File: rtl/trim_sel_counter.sv
module trim_sel_counter
    import trim_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_go,
    input  logic [2:0]        key_reg,
    input  logic              mid_fall,
    output vreg_e             sel_q,
    output logic [CODE_W-1:0] code_q
);
    localparam logic [CODE_W-1:0] CODE_ONE  = CODE_W'(1);
    localparam logic [CODE_W-1:0] CODE_ZERO = '0;

    vreg_e key_sel;
    assign key_sel = decode_key(key_reg);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= VREG_NONE;
            code_q <= CODE_ZERO;
        end else if (key_go) begin
            sel_q  <= key_sel;
            code_q <= (key_sel == VREG_NONE) ? CODE_ZERO : CODE_ONE;
        end else if (mid_fall && (sel_q != VREG_NONE)) begin
            code_q <= code_q + CODE_ONE;
        end
    end

endmodule

// File: rtl/trim_view_map.sv
module trim_view_map
    import trim_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int CHK_LO  = 8,
    parameter int CHK_HI  = 9
) (
    input  vreg_e             sel,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] trial_mag,
    output logic              trial_pol,
    output outctl_t           trial_out,
    output fchk_t             trial_chk
);
    localparam int OUT_W = $bits(outctl_t);
    localparam logic [CODE_W-1:0] OUT_LIMIT = CODE_W'(1 << OUT_W);
    localparam logic [CODE_W-1:0] CODE_LO   = CODE_W'(CHK_LO);
    localparam logic [CODE_W-1:0] CODE_HI   = CODE_W'(CHK_HI);

    logic point_sel, down_sel, out_sel;
    assign point_sel = is_point_view(sel);
    assign down_sel  = is_down_view(sel);
    assign out_sel   = (sel == VREG_OUT);

    logic [CODE_W-1:0] mapped;
    for (genvar b = 0; b < CODE_W; b++) begin : g_bit
        assign mapped[b] = code[b] ^ down_sel;
    end

    always_comb begin
        trial_mag = point_sel ? mapped : '0;
        trial_pol = point_sel & is_north_view(sel);
        trial_out = '0;
        if (out_sel && (code < OUT_LIMIT)) begin
            trial_out.inv  = code[2];
            trial_out.fall = code[1:0];
        end
        trial_chk.intact = out_sel && (code == CODE_LO);
        trial_chk.blown  = out_sel && (code == CODE_HI);
    end

endmodule

// File: rtl/trim_merge.sv
module trim_merge
    import trim_pkg::*;
#(
    parameter int MAG_W = 8
) (
    input  logic [MAG_W-1:0] fuse_mag,
    input  logic             fuse_pol,
    input  outctl_t          fuse_out,
    input  logic [MAG_W-1:0] trial_mag,
    input  logic             trial_pol,
    input  outctl_t          trial_out,
    output logic [MAG_W-1:0] eff_mag,
    output logic             eff_pol,
    output outctl_t          eff_out
);
    assign eff_mag = fuse_mag | trial_mag;
    assign eff_pol = fuse_pol | trial_pol;
    assign eff_out = fuse_out | trial_out;
endmodule

// File: rtl/trim_try_core.sv
module trim_try_core
    import trim_pkg::*;
#(
    parameter int MAG_W  = 8,
    parameter int CHK_LO = 8,
    parameter int CHK_HI = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_go,
    input  logic [2:0]       key_reg,
    input  logic             mid_fall,
    input  logic [MAG_W-1:0] fuse_mag,
    input  logic             fuse_pol,
    input  logic [1:0]       fuse_fall,
    input  logic             fuse_inv,
    output logic [MAG_W-1:0] op_mag,
    output logic             op_pol,
    output logic [1:0]       out_fall,
    output logic             out_inv,
    output logic             chk_intact,
    output logic             chk_blown
);
    vreg_e             sel_q;
    logic [MAG_W-1:0]  code_q;
    logic [MAG_W-1:0]  trial_mag;
    logic              trial_pol;
    outctl_t           trial_out;
    fchk_t             trial_chk;
    outctl_t           fuse_out;
    outctl_t           eff_out;

    assign fuse_out = '{fall: fuse_fall, inv: fuse_inv};

    trim_sel_counter #(.CODE_W(MAG_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .key_go   (key_go),
        .key_reg  (key_reg),
        .mid_fall (mid_fall),
        .sel_q    (sel_q),
        .code_q   (code_q)
    );

    trim_view_map #(.CODE_W(MAG_W), .CHK_LO(CHK_LO), .CHK_HI(CHK_HI)) u_map (
        .sel       (sel_q),
        .code      (code_q),
        .trial_mag (trial_mag),
        .trial_pol (trial_pol),
        .trial_out (trial_out),
        .trial_chk (trial_chk)
    );

    trim_merge #(.MAG_W(MAG_W)) u_mrg (
        .fuse_mag  (fuse_mag),
        .fuse_pol  (fuse_pol),
        .fuse_out  (fuse_out),
        .trial_mag (trial_mag),
        .trial_pol (trial_pol),
        .trial_out (trial_out),
        .eff_mag   (op_mag),
        .eff_pol   (op_pol),
        .eff_out   (eff_out)
    );

    assign out_fall   = eff_out.fall;
    assign out_inv    = eff_out.inv;
    assign chk_intact = trial_chk.intact;
    assign chk_blown  = trial_chk.blown;

endmodule

// File: rtl/trim_try_chk.sv
module trim_try_chk #(
    parameter int MAG_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             key_go,
    input logic             mid_fall,
    input logic [2:0]       sel_q,
    input logic [MAG_W-1:0] code_q,
    input logic [MAG_W-1:0] fuse_mag,
    input logic [MAG_W-1:0] op_mag,
    input logic             chk_intact,
    input logic             chk_blown
);
    localparam logic [MAG_W-1:0] TOP = '1;

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (code_q == '0) && (sel_q == 3'd0));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mid_fall && !key_go && sel_q != 3'd0 && code_q != TOP)
        |=> code_q == $past(code_q) + 1'b1);

    // R4
    count_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (mid_fall && !key_go && sel_q != 3'd0 && code_q == TOP)
        |=> code_q == '0);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mid_fall && !key_go && sel_q == 3'd0) |=> $stable(code_q));

    // R11
    key_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (key_go && mid_fall && sel_q != 3'd0 && code_q == 8'd5)
        |=> (code_q != 8'd6));

    // R8
    chk_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({chk_intact, chk_blown}) <= 1);

    // R9
    fuse_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (op_mag & fuse_mag) == fuse_mag);

endmodule

bind trim_try_core trim_try_chk #(.MAG_W(MAG_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .key_go     (key_go),
    .mid_fall   (mid_fall),
    .sel_q      (sel_q),
    .code_q     (code_q),
    .fuse_mag   (fuse_mag),
    .op_mag     (op_mag),
    .chk_intact (chk_intact),
    .chk_blown  (chk_blown)
);

// File: tb/sim_trim_try_core.sv
module sim_trim_try_core;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_go = 1'b0;
    logic [2:0] key_reg = 3'd0;
    logic       mid_fall = 1'b0;
    logic [7:0] fuse_mag = 8'd0;
    logic       fuse_pol = 1'b0;
    logic [1:0] fuse_fall = 2'd0;
    logic       fuse_inv = 1'b0;
    logic [7:0] op_mag;
    logic       op_pol;
    logic [1:0] out_fall;
    logic       out_inv;
    logic       chk_intact;
    logic       chk_blown;

    int checked = 0;
    int failed  = 0;
    bit done    = 0;

    logic [2:0] m_sel = 3'd0;
    logic [7:0] m_cnt = 8'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trim_try_core u0 (
        .clk(clk), .rst(rst), .key_go(key_go), .key_reg(key_reg),
        .mid_fall(mid_fall), .fuse_mag(fuse_mag), .fuse_pol(fuse_pol),
        .fuse_fall(fuse_fall), .fuse_inv(fuse_inv), .op_mag(op_mag),
        .op_pol(op_pol), .out_fall(out_fall), .out_inv(out_inv),
        .chk_intact(chk_intact), .chk_blown(chk_blown)
    );

    function automatic logic [7:0] exp_mag(input logic [2:0] s, input logic [7:0] c);
        if (s == 3'd1 || s == 3'd2) return fuse_mag | c;          // R5 up views
        if (s == 3'd3 || s == 3'd4) return fuse_mag | (8'd255 - c); // R5 down views
        return fuse_mag;
    endfunction

    function automatic logic exp_pol(input logic [2:0] s);
        return fuse_pol | (s == 3'd2 || s == 3'd4);               // R6
    endfunction

    function automatic logic [2:0] exp_out(input logic [2:0] s, input logic [7:0] c);
        logic [2:0] t;
        t = (s == 3'd5 && c < 8'd8) ? c[2:0] : 3'd0;              // R7
        return {fuse_inv, fuse_fall} | t;                           // R9
    endfunction

    task automatic model_edge();
        if (rst) begin
            m_sel = 3'd0; m_cnt = 8'd0;
        end else if (key_go) begin
            m_sel = (key_reg >= 3'd1 && key_reg <= 3'd5) ? key_reg : 3'd0;
            m_cnt = (m_sel != 3'd0) ? 8'd1 : 8'd0;
        end else if (mid_fall && m_sel != 3'd0) begin
            m_cnt = m_cnt + 8'd1;
        end
    endtask

    task automatic check_all(input string req);
        logic [7:0] em; logic ep; logic [2:0] eo; logic ei, eb; bit bad;
        em = exp_mag(m_sel, m_cnt);
        ep = exp_pol(m_sel);
        eo = exp_out(m_sel, m_cnt);
        ei = (m_sel == 3'd5 && m_cnt == 8'd8);                      // R8
        eb = (m_sel == 3'd5 && m_cnt == 8'd9);
        bad = 0;
        checked++;
        if (op_mag !== em) begin bad = 1; $display("FAIL %s op_mag act=%0d exp=%0d", req, op_mag, em); end
        if (op_pol !== ep) begin bad = 1; $display("FAIL %s op_pol act=%0b exp=%0b", req, op_pol, ep); end
        if ({out_inv, out_fall} !== eo) begin bad = 1; $display("FAIL %s out act=%0d exp=%0d", req, {out_inv, out_fall}, eo); end
        if (chk_intact !== ei) begin bad = 1; $display("FAIL %s chk_intact act=%0b exp=%0b", req, chk_intact, ei); end
        if (chk_blown !== eb) begin bad = 1; $display("FAIL %s chk_blown act=%0b exp=%0b", req, chk_blown, eb); end
        if (bad) failed++;
    endtask

    task automatic cyc(input bit r, input bit k, input logic [2:0] kr, input bit m, input string req);
        rst = r; key_go = k; key_reg = kr; mid_fall = m;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all(req);
        rst = 0; key_go = 0; mid_fall = 0;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failed++;
            $display("FAIL watchdog act=expired exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checked, failed);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd4242));
        @(negedge clk);
        cyc(1, 0, 3'd0, 0, "R1");
        cyc(1, 1, 3'd3, 1, "R1");
        // R10: pulses with nothing selected
        for (int i = 0; i < 4; i++) cyc(0, 0, 3'd0, 1, "R10");
        // R4, R5, R6: sweep each point view through wrap
        for (int v = 1; v <= 4; v++) begin
            cyc(1, 0, 3'd0, 0, "R1");
            cyc(0, 1, 3'(v), 0, "R2");
            for (int i = 0; i < 256; i++) cyc(0, 0, 3'd0, 1, (i == 254) ? "R4" : "R5");
            cyc(0, 0, 3'd0, 1, "R6");
        end
        // R7, R8: output register codes 1..10
        cyc(0, 1, 3'd5, 0, "R2");
        for (int i = 0; i < 9; i++) cyc(0, 0, 3'd0, 1, (i >= 6) ? "R8" : "R7");
        // R11: key and pulse together
        cyc(0, 1, 3'd2, 0, "R2");
        for (int i = 0; i < 4; i++) cyc(0, 0, 3'd0, 1, "R3");
        cyc(0, 1, 3'd2, 1, "R11");
        // R9: fuses OR'd with trial bits
        fuse_mag = 8'hA5; fuse_pol = 1'b1; fuse_fall = 2'b10; fuse_inv = 1'b0;
        cyc(0, 1, 3'd3, 0, "R9");
        cyc(0, 1, 3'd5, 0, "R9");
        cyc(0, 0, 3'd0, 1, "R9");
        cyc(1, 0, 3'd0, 0, "R1");
        // Unused key codes deselect
        cyc(0, 1, 3'd6, 0, "R2");
        cyc(0, 0, 3'd0, 1, "R10");
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            bit r, k, m; logic [2:0] kr;
            if (($urandom % 200) == 0) begin
                fuse_mag = 8'($urandom) & 8'($urandom); fuse_pol = 1'($urandom % 4 == 0);
                fuse_fall = 2'($urandom) & 2'($urandom); fuse_inv = 1'($urandom % 4 == 0);
            end
            r  = ($urandom % 500) == 0;
            k  = ($urandom % 40) == 0;
            kr = 3'($urandom);
            m  = ($urandom % 3) != 0;
            cyc(r, k, kr, m, (k && m) ? "R11" : "R3");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checked, failed);
        $finish;
    end
endmodule